// File: doc/BRIEF.md
# Hardware Return-Address Stack

This block keeps the return addresses of a small processor core in dedicated storage that no software path can reach. When the core executes a subroutine call or takes an interrupt, it asserts a push request with the current program counter. When it executes a return of either kind, it asserts a pop request. The block always presents the most recently saved address on its output, so the core can load it into the program counter during the pop cycle. The stack has a fixed number of levels. Once every level is in use, a further push replaces the oldest saved address. The stack never refuses a call.

The block also decides when an interrupt may be acknowledged. An unmasked interrupt request is held in a pending flag. The acknowledge pulse is sent only while at least one level is free. If the stack is full, the request stays pending. It is acknowledged right after a return frees a level. The core's instruction decode, the interrupt priority logic and the program counter incrementer are all outside this block.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset, empty_o is 1, full_o is 0 and irq_ack_o is 0.
- R2: A push saves pc_i, and from the next cycle pc_o shows that value. push_i and pop_i are never high in the same cycle; this is a rule for the caller.
- R3: A pop removes the newest entry. From the next cycle pc_o shows the entry saved before it, so addresses come back in last-in, first-out order.
- R4: With the default depth, full_o rises after 8 pushes with no pops in between. empty_o falls after any push and rises again when the last entry has been popped.
- R5: A push while full_o is high overwrites the oldest entry. full_o stays high, and the most recent 8 addresses come back in newest-first order.
- R6: A pop while empty_o is high changes nothing. empty_o stays 1, pc_o keeps its value, and no underflow is signalled.
- R7: A one-cycle pulse on irq_req_i sets a pending flag. If the stack is not full, irq_ack_o is high for exactly one cycle, starting the cycle after the request.
- R8: While full_o is high, irq_ack_o stays 0 and a pending request is kept.
- R9: When a pop takes a full stack down by one level while a request is pending, irq_ack_o goes high in the cycle right after that pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Save pc_i (call or interrupt entry) |
| pop_i | input | 1 | Discard the newest entry (return) |
| pc_i | input | PC_W | Program counter value to save |
| irq_req_i | input | 1 | Unmasked interrupt request pulse |
| pc_o | output | PC_W | Newest saved address (restore value) |
| full_o | output | 1 | All levels in use |
| empty_o | output | 1 | No level in use |
| irq_ack_o | output | 1 | One-cycle interrupt acknowledge |

## Verification
The stack is first driven with a short mixed sequence of pushes and pops. Because each pushed address is distinct, a pointer that moves the wrong way, or a top index that is off by one, shows up as a wrong address. Next comes an unbroken run of nine pushes followed by nine pops. This run separates a stack that overwrites its oldest entry from one that refuses the extra push or corrupts its newest entry. It also shows whether the empty flag and the pointer stay put when a pop finds the stack empty. Finally, interrupt requests are sent once with free levels and once with the stack full. These two cases separate plain acknowledgment from acknowledgment that is held back and then released by a pop.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } stk_op_e;

    localparam int unsigned DEF_DEPTH = 8;
    localparam int unsigned DEF_PC_W  = 13;

endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
    import ras_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic [PTR_W-1:0] rd_idx_o,
    output logic             full_o,
    output logic             empty_o
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [CNT_W-1:0] cnt;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    stk_op_e    op;

    function automatic logic [PTR_W-1:0] idx_inc(input logic [PTR_W-1:0] v);
        return (v == LAST_IDX) ? '0 : v + PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] idx_dec(input logic [PTR_W-1:0] v);
        return (v == '0) ? LAST_IDX : v - PTR_W'(1);
    endfunction

    always_comb begin
        if (push_i)     op = OP_PUSH;
        else if (pop_i) op = OP_POP;
        else            op = OP_IDLE;
    end

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_PUSH: begin
                st_d.ptr = idx_inc(st_q.ptr);
                if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + CNT_W'(1);
            end
            OP_POP: begin
                if (st_q.cnt != '0) begin
                    st_d.ptr = idx_dec(st_q.ptr);
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en_o  = (op == OP_PUSH);
    assign wr_idx_o = st_q.ptr;
    assign rd_idx_o = idx_dec(st_q.ptr);
    assign full_o   = (st_q.cnt == CNT_MAX);
    assign empty_o  = (st_q.cnt == '0);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX); // R4
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !push_i) |=> (empty_o && $stable(st_q.ptr))); // R6
    AST_FULL_STAYS_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i) |=> full_o); // R5
    AST_NOT_BOTH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o)); // R4

endmodule

// File: rtl/ras_storage.sv
module ras_storage
    import ras_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    parameter int unsigned PC_W  = DEF_PC_W,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_idx_i,
    input  logic [PC_W-1:0]  wr_data_i,
    input  logic [PTR_W-1:0] rd_idx_i,
    output logic [PC_W-1:0]  rd_data_o
);

    logic [PC_W-1:0] slot_d [DEPTH];
    logic [PC_W-1:0] slot_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_comb begin
            slot_d[gi] = slot_q[gi];
            if (wr_en_i && (wr_idx_i == PTR_W'(gi))) slot_d[gi] = wr_data_i;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) slot_q[gi] <= '0;
            else        slot_q[gi] <= slot_d[gi];
        end
    end

    assign rd_data_o = slot_q[rd_idx_i];

endmodule

// File: rtl/ras_irq_gate.sv
module ras_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req_i,
    input  logic full_i,
    input  logic pop_i,
    output logic irq_ack_o
);

    typedef struct packed {
        logic pend;
    } gate_state_t;

    gate_state_t st_d, st_q;
    logic        ack;

    always_comb begin
        ack     = st_q.pend && !full_i;
        st_d    = st_q;
        if (ack) st_d.pend = 1'b0;
        if (irq_req_i) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_ack_o = ack;

    AST_FULL_BLOCKS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        full_i |-> !irq_ack_o); // R8
    AST_PEND_KEPT_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && full_i) |=> st_q.pend); // R8
    AST_ACK_AFTER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && full_i && pop_i) |=> irq_ack_o); // R9
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_o && !irq_req_i) |=> !irq_ack_o); // R7

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
    import ras_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    parameter int unsigned PC_W  = DEF_PC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic            irq_req_i,
    output logic [PC_W-1:0] pc_o,
    output logic            full_o,
    output logic            empty_o,
    output logic            irq_ack_o
);

    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_idx;
    logic             full;

    ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push_i),
        .pop_i    (pop_i),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx),
        .rd_idx_o (rd_idx),
        .full_o   (full),
        .empty_o  (empty_o)
    );

    ras_storage #(.DEPTH(DEPTH), .PC_W(PC_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (pc_i),
        .rd_idx_i  (rd_idx),
        .rd_data_o (pc_o)
    );

    ras_irq_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req_i (irq_req_i),
        .full_i    (full),
        .pop_i     (pop_i),
        .irq_ack_o (irq_ack_o)
    );

    assign full_o = full;

    AST_NO_PUSH_WITH_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i)); // R2
    AST_PUSH_LANDS_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (pc_o == $past(pc_i))); // R2
    AST_PUSH_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> !empty_o); // R4

endmodule

// File: tb/ret_addr_stack_tb_top.sv
`timescale 1ns/1ps
module ret_addr_stack_tb_top;

    localparam int PC_W  = 13;
    localparam int DEPTH = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            push_i = 1'b0;
    logic            pop_i = 1'b0;
    logic [PC_W-1:0] pc_i = '0;
    logic            irq_req_i = 1'b0;
    logic [PC_W-1:0] pc_o;
    logic            full_o;
    logic            empty_o;
    logic            irq_ack_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ret_addr_stack #(.DEPTH(DEPTH), .PC_W(PC_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .pc_i      (pc_i),
        .irq_req_i (irq_req_i),
        .pc_o      (pc_o),
        .full_o    (full_o),
        .empty_o   (empty_o),
        .irq_ack_o (irq_ack_o)
    );

    // vector: op(2: 0 idle,1 push,2 pop) | pc(13) | expected top(13) | full | empty
    localparam logic [29:0] VEC [0:8] = '{
        {2'd1, 13'h0100, 13'h0100, 1'b0, 1'b0},
        {2'd1, 13'h0201, 13'h0201, 1'b0, 1'b0},
        {2'd1, 13'h0302, 13'h0302, 1'b0, 1'b0},
        {2'd2, 13'h0000, 13'h0201, 1'b0, 1'b0},
        {2'd2, 13'h0000, 13'h0100, 1'b0, 1'b0},
        {2'd1, 13'h1FFF, 13'h1FFF, 1'b0, 1'b0},
        {2'd2, 13'h0000, 13'h0100, 1'b0, 1'b0},
        {2'd2, 13'h0000, 13'h0000, 1'b0, 1'b1},
        {2'd2, 13'h0000, 13'h0000, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input bit psh, input bit pp, input int pc, input bit irq);
        @(negedge clk);
        push_i    = psh;
        pop_i     = pp;
        pc_i      = PC_W'(pc);
        irq_req_i = irq;
        @(posedge clk);
        #1;
        @(negedge clk);
        push_i    = 1'b0;
        pop_i     = 1'b0;
        irq_req_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 empty", int'(empty_o), 1);
        chk("R1 full", int'(full_o), 0);
        chk("R1 ack", int'(irq_ack_o), 0);

        // table walk: R2 push top, R3 LIFO, R4 empty again, R6 pop on empty
        for (int i = 0; i < 9; i++) begin
            step(VEC[i][29:28] == 2'd1, VEC[i][29:28] == 2'd2, int'(VEC[i][27:15]), 1'b0);
            chk($sformatf("R2/R3 top step %0d", i), int'(pc_o), int'(VEC[i][14:2]));
            chk($sformatf("R4 full step %0d", i), int'(full_o), int'(VEC[i][1]));
            chk($sformatf("R6 empty step %0d", i), int'(empty_o), int'(VEC[i][0]));
        end

        // R4 fill to full
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 1'b0, 'h10 + i, 1'b0);
            chk("R4 full after fill", int'(full_o), (i == DEPTH - 1) ? 1 : 0);
        end
        // R5 overwrite oldest
        step(1'b1, 1'b0, 'h99, 1'b0);
        chk("R5 full kept", int'(full_o), 1);
        chk("R5 new top", int'(pc_o), 'h99);
        step(1'b0, 1'b1, 0, 1'b0);
        chk("R5 below new top", int'(pc_o), 'h17);
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b1, 0, 1'b0);
            chk("R5 newest-first order", int'(pc_o), 'h16 - i);
        end
        chk("R5 oldest survivor", int'(pc_o), 'h11);
        chk("R5 not yet empty", int'(empty_o), 0);
        step(1'b0, 1'b1, 0, 1'b0);
        chk("R4 empty after last pop", int'(empty_o), 1);
        step(1'b0, 1'b1, 0, 1'b0);
        chk("R6 empty stays", int'(empty_o), 1);
        chk("R6 full stays low", int'(full_o), 0);
        step(1'b1, 1'b0, 'h55, 1'b0);
        chk("R6 pointer unchanged, push lands", int'(pc_o), 'h55);
        step(1'b0, 1'b1, 0, 1'b0);

        // R7 ack with room
        @(negedge clk);
        irq_req_i = 1'b1;
        @(posedge clk);
        #1;
        chk("R7 ack next cycle", int'(irq_ack_o), 1);
        @(negedge clk);
        irq_req_i = 1'b0;
        @(posedge clk);
        #1;
        chk("R7 ack one cycle", int'(irq_ack_o), 0);

        // R8 blocked while full, R9 released by pop
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 'h200 + i, 1'b0);
        chk("R8 full", int'(full_o), 1);
        @(negedge clk);
        irq_req_i = 1'b1;
        @(posedge clk);
        #1;
        chk("R8 no ack when full", int'(irq_ack_o), 0);
        @(negedge clk);
        irq_req_i = 1'b0;
        repeat (3) begin
            @(posedge clk);
            #1;
            chk("R8 still held", int'(irq_ack_o), 0);
        end
        @(negedge clk);
        pop_i = 1'b1;
        @(posedge clk);
        #1;
        chk("R9 ack after pop", int'(irq_ack_o), 1);
        chk("R9 top after pop", int'(pc_o), 'h206);
        @(negedge clk);
        pop_i = 1'b0;
        @(posedge clk);
        #1;
        chk("R9 ack one cycle", int'(irq_ack_o), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule